// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog countdown timer that software controls through one 32-bit configuration word on a simple synchronous register port: a write strobe with write data, and read data that is always valid. Starting, stopping and servicing the timer are each guarded by a two-write key handshake on a 2-bit field of that word. A single stray or corrupted write can therefore never start, stop or feed the timer.

The word carries a 24-bit reload value. Each count of that value stands for 256 clock cycles, produced by an internal prescaler. While the timer runs, the countdown decrements once per prescaler period. When the countdown expires, the block pulses its timeout output and begins a new period. Whatever consumes that pulse (an interrupt line or a reset generator) lives outside the block.

Top module: `wdtKeyed`

## Requirements
- R1: After reset, the read data is all zeros: the timer is stopped and the stored reload value is 0. The timeout output is low.
- R2: A key field acts only when one write puts code 1 in it and the very next write puts code 2 in it. A write that puts any value other than 2 in the field after a 1 returns its tracker to idle, and so does any value other than 1 written while idle. So a lone 2, the series 1,1,2 and the series 1,0,2 all do nothing.
- R3: Completing the key pair on the run-key field, bits 25:24, toggles the timer between running and stopped. Bit 31 of the read data is 1 while running and 0 while stopped.
- R4: Every write stores its bits 23:0 as the reload value, and these read back on bits 23:0. Bits 30:24 read as 0. Writing 1 to bit 31 does not change the running state.
- R5: The write that starts the timer loads the countdown with its own bits 23:0 (N) and clears the prescaler. For N of 1 or more, the first timeout pulse becomes visible 256*N clock edges after that write's edge.
- R6: Each timeout pulse lasts exactly one clock cycle. The countdown then reloads from the stored reload value, so pulses repeat every 256*N cycles.
- R7: Completing the key pair on the service field, bits 27:26, while running restarts a full 256*N period, counted from the completing write.
- R8: While stopped, the timeout never asserts. A completed service key pair has no visible effect: the running bit stays 0 and no timeout follows.
- R9: Completing the run-key pair again while running stops the timer, and no further timeout pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the prescaler counts its rising edges |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| wrData | input | 32 | Write data: reload value, run key, service key |
| rdData | output | 32 | Read data: running flag in bit 31, reload value in bits 23:0 |
| timeout | output | 1 | One-cycle pulse on countdown expiry |

## Verification
The bench sweeps reload values 1 to 4 and measures the exact edge of each timeout. A prescaler off by one cycle, or a countdown that fires at zero instead of at one, shows up as a shifted edge. Broken key handshakes, such as 1,1,2, 1,0,2 or a lone 2, are fed to the run key. A tracker that stays armed, or that fires on a 2 without a preceding 1, would start the timer, and bit 31 would read 1. The bench services the timer midway through a period and checks that the next timeout moves out by a full period. Servicing a stopped timer and writing 1 to bit 31 are both checked as having no effect. A stale reload, a leaked enable, or a timeout pulse wider than one cycle would each show at the pins.

// File: rtl/wdtKeyedPkg.sv
package wdtKeyedPkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic loadCnt;   // load countdown from the written reload value
    logic clearPre;  // restart the prescaler
    logic runEn;     // timer is running this cycle
  } wdtStrobe_t;

  localparam int KEY_W     = 2;
  localparam int KEY_ARM   = 1;
  localparam int KEY_FIRE  = 2;
endpackage

// File: rtl/wdtKeyTracker.sv
module wdtKeyTracker
  import wdtKeyedPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [KEY_W-1:0] keyField,
  output logic             fire
);
  logic armed;

  assign fire = wrEn && armed && (keyField == KEY_W'(KEY_FIRE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (wrEn) begin
      armed <= !armed && (keyField == KEY_W'(KEY_ARM));
    end
  end

  // R2: a tracker only arms on a write carrying the arm code while idle
  assert_arm_needs_code1_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(wrEn && keyField == KEY_W'(KEY_ARM)));
endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtKeyedPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RUN_LSB = 24,
  parameter int SVC_LSB = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output wdtStrobe_t        strobe,
  output logic              running
);
  localparam int NUM_KEYS = 2;
  logic [NUM_KEYS-1:0] keyFire;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : gKey
    localparam int LSB = (g == 0) ? RUN_LSB : SVC_LSB;
    wdtKeyTracker uTrk (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (wrEn),
      .keyField (wrData[LSB +: KEY_W]),
      .fire     (keyFire[g])
    );
  end

  logic runFire, svcFire;
  assign runFire = keyFire[0];
  assign svcFire = keyFire[1];

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else if (runFire) running <= !running;
  end

  always_comb begin
    strobe.runEn    = running;
    strobe.loadCnt  = (runFire && !running) || (svcFire && running);
    strobe.clearPre = strobe.loadCnt;
  end

  // R3: the running state changes only after a completed run-key pair
  assert_run_toggle_keyed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running != $past(running)) |-> $past(runFire));
endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtKeyedPkg::*;
#(
  parameter int RELOAD_W   = 24,
  parameter int PRESCALE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [RELOAD_W-1:0] wrReload,
  input  wdtStrobe_t          strobe,
  output logic [RELOAD_W-1:0] reloadVal,
  output logic                timeout
);
  localparam logic [PRESCALE_W-1:0] PRE_LAST = '1;

  logic [PRESCALE_W-1:0] pre;
  logic [RELOAD_W-1:0]   cnt;
  logic                  tick, expire;

  assign tick   = strobe.runEn && !strobe.loadCnt && (pre == PRE_LAST);
  assign expire = tick && (cnt <= RELOAD_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) reloadVal <= '0;
    else if (wrEn) reloadVal <= wrReload;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else if (strobe.clearPre) pre <= '0;
    else if (strobe.runEn) pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire;
      if (strobe.loadCnt) cnt <= wrReload;
      else if (expire) cnt <= reloadVal;
      else if (tick) cnt <= cnt - 1'b1;
    end
  end

  // R6: the timeout pulse lasts a single cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);
  // R8: no timeout unless the timer was running
  assert_no_timeout_stopped_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> $past(strobe.runEn));
  // R8: a stopped timer keeps its countdown
  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.runEn && !strobe.loadCnt) |=> $stable(cnt));
endmodule

// File: rtl/wdtKeyed.sv
module wdtKeyed
  import wdtKeyedPkg::*;
#(
  parameter int RELOAD_W   = 24,
  parameter int PRESCALE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        timeout
);
  localparam int DATA_W   = 32;
  localparam int RUN_LSB  = 24;
  localparam int SVC_LSB  = 26;
  localparam int STAT_BIT = DATA_W - 1;

  wdtStrobe_t          strobe;
  logic                running;
  logic [RELOAD_W-1:0] reloadVal;

  wdtControl #(.DATA_W(DATA_W), .RUN_LSB(RUN_LSB), .SVC_LSB(SVC_LSB)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobe  (strobe),
    .running (running)
  );

  wdtDatapath #(.RELOAD_W(RELOAD_W), .PRESCALE_W(PRESCALE_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrReload  (wrData[RELOAD_W-1:0]),
    .strobe    (strobe),
    .reloadVal (reloadVal),
    .timeout   (timeout)
  );

  always_comb begin
    rdData                 = '0;
    rdData[RELOAD_W-1:0]   = reloadVal;
    rdData[STAT_BIT]       = running;
  end
endmodule

// File: tb/tb_wdtKeyed.sv
module tb_wdtKeyed;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        timeout;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  wdtKeyed dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .timeout(timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] word(int runKey, int svcKey, int reload);
    return (32'(runKey) << 24) | (32'(svcKey) << 26) | 32'(reload);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  // Wait up to maxCyc edges; return edge index of first timeout, 0 if none
  task automatic waitTimeout(int maxCyc, output int at);
    at = 0;
    for (int m = 1; m <= maxCyc; m++) begin
      @(negedge clk);
      if (timeout && at == 0) begin at = m; return; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int at;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 32'h0);
    check("R1 timeout", 32'(timeout), 32'h0);

    // R4 reload readback, reserved zero, bit31 write ignored
    wr(32'hFF00_1234 & ~(32'hF << 24) | 32'h8000_0000);
    check("R4 readback", rdData, 32'h0000_1234);
    wr(word(0, 0, 24'hABCDEF) | 32'h7000_0000);
    check("R4 reserved", rdData, 32'h00AB_CDEF);

    // R2 broken key sequences on run key
    wr(word(2, 0, 1));
    check("R2 lone 2", 32'(rdData[31]), 32'h0);
    wr(word(1, 0, 1)); wr(word(1, 0, 1)); wr(word(2, 0, 1));
    check("R2 1,1,2", 32'(rdData[31]), 32'h0);
    wr(word(1, 0, 1)); wr(word(0, 0, 1)); wr(word(2, 0, 1));
    check("R2 1,0,2", 32'(rdData[31]), 32'h0);
    wr(word(1, 0, 1)); wr(word(3, 0, 1)); wr(word(2, 0, 1));
    check("R2 1,3,2", 32'(rdData[31]), 32'h0);

    // R8 service while stopped has no effect
    wr(word(0, 1, 1)); wr(word(0, 2, 1));
    check("R8 svc stopped status", 32'(rdData[31]), 32'h0);
    waitTimeout(700, at);
    check("R8 no timeout stopped", 32'(at), 32'h0);

    // R5/R6 sweep of reload values
    for (int n = 1; n <= 4; n++) begin
      wr(word(1, 0, n)); wr(word(2, 0, n));
      check("R3 running bit", 32'(rdData[31]), 32'h1);
      waitTimeout(TICKS * n + 10, at);
      check("R5 first timeout edge", 32'(at), 32'(TICKS * n));
      @(negedge clk);
      check("R6 pulse width", 32'(timeout), 32'h0);
      waitTimeout(TICKS * n + 10, at);
      check("R6 period", 32'(at + 1), 32'(TICKS * n));
      // R9 stop via run key pair
      wr(word(1, 0, n)); wr(word(2, 0, n));
      check("R9 stopped bit", 32'(rdData[31]), 32'h0);
    end
    waitTimeout(1500, at);
    check("R9 no timeout after stop", 32'(at), 32'h0);

    // R7 service restarts full period
    wr(word(1, 0, 3)); wr(word(2, 0, 3));
    waitTimeout(300, at);
    check("R7 none before service", 32'(at), 32'h0);
    wr(word(0, 1, 3)); wr(word(0, 2, 3));
    waitTimeout(TICKS * 3 + 10, at);
    check("R7 period after service", 32'(at), 32'(TICKS * 3));

    // R4 bit31 write does not stop a running timer
    wr(32'h8000_0003);
    check("R4 bit31 write ignored", 32'(rdData[31]), 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule